// File: doc/BRIEF.md
# Dirty-Page Write Logger

The block keeps a log of guest-physical pages that become dirty. Every write event arrives with the page's guest-physical address and the dirty flag the page holds at that moment. If the page is still clean, the unit marks it dirty and stores the page address, aligned to its 4 KiB frame, in an internal log buffer of 512 entries. The slot for each entry comes from a 16-bit index that counts down. Software starts the index at 511, so the first entry lands in the top slot. After each stored entry the index drops by one.

The index is checked before each event is handled. If any bit above the slot field (bits 15:9) is set, the unit does not touch the buffer and does not mark the page. It raises a one-cycle exit pulse and refuses further events until software writes a new index. The buffer is full only when the index reads 0xFFFF, which is the value reached by stepping down from 0. Any other out-of-range value means the index was set up wrongly and no entry was written. Software reads the index back on a dedicated output and can inspect any buffer slot through a read port.

Top module: `dirty_log_unit`

## Requirements
- R1: After reset the index output reads 0xFFFF, the exit pulse is low, no buffer write is signalled and evReady is high.
- R2: While idxLoad is high, evReady is low. In the cycle after idxLoad, idxOut holds the value that was on idxLoadVal, and a halted unit resumes accepting events.
- R3: An event accepted while idxOut[15:9] is nonzero raises exitPulse in the next cycle for exactly one cycle. It causes no buffer write and no markDirty, and it leaves the index unchanged. This holds whether the page is clean or dirty.
- R4: After an exit, evReady stays low and events have no effect on the index or the buffer until idxLoad is asserted.
- R5: An event accepted with an in-range index on a clean page (evDirty=0) gives, in the next cycle, bufWrEn and markDirty high for exactly one cycle, with bufWrIdx equal to idxOut[8:0].
- R6: bufWrData equals the event address with bits 11:0 forced to zero.
- R7: At the clock edge that ends a write cycle, the index decreases by one. Stepping down from 0 gives 0xFFFF, and the next accepted event then raises an exit.
- R8: An event accepted with an in-range index on a page already dirty (evDirty=1) causes no write, no markDirty and no exit, and leaves the index unchanged.
- R9: evReady is low in every cycle in which bufWrEn is high.
- R10: rdData returns the entry last written to slot rdIdx.
- R11: After the index is loaded with 511, the first logged entry goes to slot 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Write event present |
| evReady | output | 1 | Unit can take an event this cycle |
| evGpa | input | 48 | Guest-physical address of the write |
| evDirty | input | 1 | Current dirty flag of the written page |
| idxLoad | input | 1 | Load strobe for the index |
| idxLoadVal | input | 16 | Value to load into the index |
| idxOut | output | 16 | Current index |
| bufWrEn | output | 1 | Buffer write performed this cycle |
| bufWrIdx | output | 9 | Slot being written |
| bufWrData | output | 48 | Aligned page address being written |
| markDirty | output | 1 | Request to set the page's dirty flag |
| exitPulse | output | 1 | One-cycle exit request |
| rdIdx | input | 9 | Buffer slot to read |
| rdData | output | 48 | Contents of slot rdIdx |

## Verification
The assertions assume that evGpa and evDirty belong to the event being offered and stay fixed while evValid waits for evReady. They also assume that software asserts idxLoad only when it means to re-arm or reposition the log. The stimulus holds each event stable until it is taken, or drops it after a short bounded wait when the unit is halted. It drives idxLoad only between events, except in one deliberate case that checks the load gating of evReady. It uses in-range, full (0xFFFF) and malformed index values, which covers every state in which the checks apply.

// File: rtl/dirty_log_pkg.sv
package dirty_log_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_HALT  = 2'd2
  } logState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // latch aligned address for a pending write
    logic commit;    // write pending entry, step index down
    logic load;      // take software index
  } logStrobes_t;

endpackage

// File: rtl/dirty_log_mem.sv
module dirty_log_mem #(
  parameter int WIDTH = 48,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  assign rdData = store[rdAddr];
endmodule

// File: rtl/dirty_log_ctrl.sv
module dirty_log_ctrl
  import dirty_log_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evValid,
  input  logic        evDirty,
  input  logic        idxLoad,
  input  logic        idxInRange,
  output logic        evReady,
  output logic        exitPulse,
  output logic        writing,
  output logStrobes_t strobes
);
  logState_t state, stateNext;
  logic accept;
  logic raiseExit;

  assign evReady   = (state == ST_IDLE) && !idxLoad;
  assign accept    = evValid && evReady;
  assign raiseExit = accept && !idxInRange;

  assign strobes.capture = accept && idxInRange && !evDirty;
  assign strobes.commit  = (state == ST_WRITE);
  assign strobes.load    = idxLoad;
  assign writing         = (state == ST_WRITE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (raiseExit)            stateNext = ST_HALT;
        else if (strobes.capture) stateNext = ST_WRITE;
      end
      ST_WRITE: stateNext = ST_IDLE;
      ST_HALT:  if (idxLoad) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      exitPulse <= 1'b0;
    end else begin
      state     <= stateNext;
      exitPulse <= raiseExit;
    end
  end
endmodule

// File: rtl/dirty_log_dp.sv
module dirty_log_dp
  import dirty_log_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter int SLOT_W     = 9,
  parameter int ADDR_W     = 48,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobes_t       strobes,
  input  logic [ADDR_W-1:0] evGpa,
  input  logic [IDX_W-1:0]  idxLoadVal,
  input  logic [SLOT_W-1:0] rdIdx,
  output logic [IDX_W-1:0]  idxOut,
  output logic              idxInRange,
  output logic [SLOT_W-1:0] bufWrIdx,
  output logic [ADDR_W-1:0] bufWrData,
  output logic [ADDR_W-1:0] rdData
);
  localparam int HIGH_W = IDX_W - SLOT_W;
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-PAGE_SHIFT){1'b1}}, {PAGE_SHIFT{1'b0}}};

  logic [IDX_W-1:0]  idxReg;
  logic [ADDR_W-1:0] pendAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg   <= '1;
      pendAddr <= '0;
    end else begin
      if (strobes.load)        idxReg <= idxLoadVal;
      else if (strobes.commit) idxReg <= idxReg - 1'b1;
      if (strobes.capture)     pendAddr <= evGpa & PAGE_MASK;
    end
  end

  generate
    if (HIGH_W > 0) begin : g_rangeChk
      assign idxInRange = (idxReg[IDX_W-1:SLOT_W] == '0);
    end else begin : g_noRange
      assign idxInRange = 1'b1;
    end
  endgenerate

  assign idxOut    = idxReg;
  assign bufWrIdx  = idxReg[SLOT_W-1:0];
  assign bufWrData = pendAddr;

  dirty_log_mem #(.WIDTH(ADDR_W), .AW(SLOT_W)) u_mem (
    .clk    (clk),
    .wrEn   (strobes.commit),
    .wrAddr (idxReg[SLOT_W-1:0]),
    .wrData (pendAddr),
    .rdAddr (rdIdx),
    .rdData (rdData)
  );
endmodule

// File: rtl/dirty_log_unit.sv
module dirty_log_unit
  import dirty_log_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter int SLOT_W     = 9,
  parameter int ADDR_W     = 48,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  output logic              evReady,
  input  logic [ADDR_W-1:0] evGpa,
  input  logic              evDirty,
  input  logic              idxLoad,
  input  logic [IDX_W-1:0]  idxLoadVal,
  output logic [IDX_W-1:0]  idxOut,
  output logic              bufWrEn,
  output logic [SLOT_W-1:0] bufWrIdx,
  output logic [ADDR_W-1:0] bufWrData,
  output logic              markDirty,
  output logic              exitPulse,
  input  logic [SLOT_W-1:0] rdIdx,
  output logic [ADDR_W-1:0] rdData
);
  logStrobes_t strobes;
  logic idxInRange;
  logic writing;

  dirty_log_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evValid    (evValid),
    .evDirty    (evDirty),
    .idxLoad    (idxLoad),
    .idxInRange (idxInRange),
    .evReady    (evReady),
    .exitPulse  (exitPulse),
    .writing    (writing),
    .strobes    (strobes)
  );

  dirty_log_dp #(
    .IDX_W(IDX_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .evGpa      (evGpa),
    .idxLoadVal (idxLoadVal),
    .rdIdx      (rdIdx),
    .idxOut     (idxOut),
    .idxInRange (idxInRange),
    .bufWrIdx   (bufWrIdx),
    .bufWrData  (bufWrData),
    .rdData     (rdData)
  );

  assign bufWrEn   = writing;
  assign markDirty = writing;
endmodule

// File: rtl/dirty_log_chk.sv
module dirty_log_chk #(
  parameter int IDX_W      = 16,
  parameter int SLOT_W     = 9,
  parameter int ADDR_W     = 48,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              evValid,
  input logic              evReady,
  input logic              evDirty,
  input logic              idxLoad,
  input logic [IDX_W-1:0]  idxLoadVal,
  input logic [IDX_W-1:0]  idxOut,
  input logic              bufWrEn,
  input logic [ADDR_W-1:0] bufWrData,
  input logic              markDirty,
  input logic              exitPulse
);
  // R3
  exit_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |=> !exitPulse);

  // R3
  exit_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |-> (!bufWrEn && !markDirty));

  // R4
  halt_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |-> !evReady);

  // R9
  ready_low_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> !evReady);

  // R7
  idx_step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufWrEn && !idxLoad) |=> (idxOut == $past(idxOut) - 1'b1));

  // R6
  page_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (bufWrData[PAGE_SHIFT-1:0] == '0));

  // R5
  write_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (idxOut[IDX_W-1:SLOT_W] == '0));

  // R8
  dirty_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evReady && evDirty) |=> !bufWrEn);

  // R2
  load_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxLoad |=> (idxOut == $past(idxLoadVal)));

  // R2
  load_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxLoad |-> !evReady);
endmodule

bind dirty_log_unit dirty_log_chk #(
  .IDX_W(IDX_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evValid    (evValid),
  .evReady    (evReady),
  .evDirty    (evDirty),
  .idxLoad    (idxLoad),
  .idxLoadVal (idxLoadVal),
  .idxOut     (idxOut),
  .bufWrEn    (bufWrEn),
  .bufWrData  (bufWrData),
  .markDirty  (markDirty),
  .exitPulse  (exitPulse)
);

// File: tb/dirty_log_unit_tb.sv
module dirty_log_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0;
  logic        evReady;
  logic [47:0] evGpa = '0;
  logic        evDirty = 1'b0;
  logic        idxLoad = 1'b0;
  logic [15:0] idxLoadVal = '0;
  logic [15:0] idxOut;
  logic        bufWrEn;
  logic [8:0]  bufWrIdx;
  logic [47:0] bufWrData;
  logic        markDirty;
  logic        exitPulse;
  logic [8:0]  rdIdx = '0;
  logic [47:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  dirty_log_unit u_dut (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady),
    .evGpa(evGpa), .evDirty(evDirty), .idxLoad(idxLoad), .idxLoadVal(idxLoadVal),
    .idxOut(idxOut), .bufWrEn(bufWrEn), .bufWrIdx(bufWrIdx), .bufWrData(bufWrData),
    .markDirty(markDirty), .exitPulse(exitPulse), .rdIdx(rdIdx), .rdData(rdData)
  );

  // Behavioural reference: 0 idle, 1 write pending, 2 halted
  int          mState = 0;
  logic [15:0] mIdx   = 16'hFFFF;
  logic [47:0] mPend  = '0;
  logic        mExit  = 1'b0;
  logic [47:0] mMem   [512];
  bit          mWritten [512];

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mIdx = 16'hFFFF; mExit = 1'b0;
    end else begin
      mExit = 1'b0;
      if (mState == 1) begin
        mMem[mIdx[8:0]] = mPend;
        mWritten[mIdx[8:0]] = 1'b1;
        mIdx = mIdx - 16'd1;
        mState = 0;
      end else if (mState == 0) begin
        if (evValid && !idxLoad) begin
          if (mIdx > 16'd511) begin
            mExit = 1'b1; mState = 2;
          end else if (!evDirty) begin
            mPend = {evGpa[47:12], 12'h000};
            mState = 1;
          end
        end
      end
      if (idxLoad) begin
        mIdx = idxLoadVal;
        if (mState == 2) mState = 0;
      end
    end
  end

  // Compare every cycle, 5 ns after the rising edge
  always @(posedge clk) begin
    #5;
    if (rstN && !done) begin
      check("R9", "evReady", 64'(evReady), 64'((mState == 0) && !idxLoad));
      check("R5", "bufWrEn", 64'(bufWrEn), 64'(mState == 1));
      check("R5", "markDirty", 64'(markDirty), 64'(mState == 1));
      check("R3", "exitPulse", 64'(exitPulse), 64'(mExit));
      check("R7", "idxOut", 64'(idxOut), 64'(mIdx));
      if (mState == 1) begin
        check("R5", "bufWrIdx", 64'(bufWrIdx), 64'(mIdx[8:0]));
        check("R6", "bufWrData", 64'(bufWrData), 64'(mPend));
      end
      if (mWritten[rdIdx]) check("R10", "rdData", 64'(rdData), 64'(mMem[rdIdx]));
    end
  end

  task automatic sendEv(input logic [47:0] gpa, input logic dirty);
    @(negedge clk);
    evValid = 1'b1; evGpa = gpa; evDirty = dirty;
    #1;
    for (int t = 0; t < 4 && !evReady; t++) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    evValid = 1'b0;
  endtask

  task automatic loadIdx(input logic [15:0] v);
    @(negedge clk);
    idxLoad = 1'b1; idxLoadVal = v;
    @(negedge clk);
    idxLoad = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin mWritten[i] = 1'b0; mMem[i] = '0; end
    idle(3);
    rstN = 1'b1;
    @(posedge clk); #5;
    // R1 reset state
    check("R1", "idxOut after reset", 64'(idxOut), 64'hFFFF);
    check("R1", "exitPulse after reset", 64'(exitPulse), 64'd0);
    check("R1", "bufWrEn after reset", 64'(bufWrEn), 64'd0);
    check("R1", "evReady after reset", 64'(evReady), 64'd1);

    // R3: event against the full value raises exit
    sendEv(48'h0000_1234_5678, 1'b0);
    idle(1);
    // R4: halted, events ignored
    sendEv(48'h0000_0000_9000, 1'b0);
    check("R4", "idx unchanged while halted", 64'(idxOut), 64'hFFFF);
    check("R4", "ready low while halted", 64'(evReady), 64'd0);

    // R2 / R11
    loadIdx(16'd511);
    #6;
    check("R2", "idxOut after load", 64'(idxOut), 64'd511);
    sendEv(48'hABCD_EF01_2FFF, 1'b0);   // write cycle coincides with this return
    #6;
    check("R11", "first slot", 64'(bufWrIdx), 64'd511);
    check("R6", "aligned data", 64'(bufWrData), 64'hABCD_EF01_2000);
    idle(1);

    // R8: already-dirty page
    sendEv(48'h0000_0000_7123, 1'b1);
    idle(1);
    #6;
    check("R8", "idx unchanged on dirty page", 64'(idxOut), 64'd510);
    check("R8", "no exit on dirty page", 64'(exitPulse), 64'd0);

    // mixed traffic
    for (int k = 0; k < 40; k++) begin
      sendEv({16'h00F0, 20'(k * 7919), 12'(k * 37)}, (k % 3) == 0);
      if (k % 5 == 0) idle(1);
    end

    // R2: load held across an offered event keeps ready low
    @(negedge clk);
    idxLoad = 1'b1; idxLoadVal = 16'd2; evValid = 1'b1; evGpa = 48'h5000; evDirty = 1'b0;
    #1;
    check("R2", "ready low during load", 64'(evReady), 64'd0);
    @(negedge clk);
    idxLoad = 1'b0; evValid = 1'b0;

    // R7: drain slots 2,1,0 then wrap to full
    sendEv(48'h0000_0001_1111, 1'b0);
    sendEv(48'h0000_0002_2222, 1'b0);
    sendEv(48'h0000_0003_3333, 1'b0);
    idle(2);
    check("R7", "wrap to full", 64'(idxOut), 64'hFFFF);
    sendEv(48'h0000_0004_4444, 1'b0);
    idle(2);

    // R3: malformed index values, clean and dirty pages
    loadIdx(16'h0200);
    sendEv(48'h0000_0005_5555, 1'b0);
    idle(2);
    check("R3", "bad index untouched", 64'(idxOut), 64'h0200);
    loadIdx(16'h1234);
    sendEv(48'h0000_0006_6666, 1'b1);
    idle(2);
    check("R3", "bad index untouched (dirty page)", 64'(idxOut), 64'h1234);
    loadIdx(16'd300);
    sendEv(48'h0000_0007_7777, 1'b0);
    idle(2);

    // R10: read back every slot
    for (int s = 0; s < 512; s++) begin
      @(negedge clk);
      rdIdx = 9'(s);
    end
    idle(2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule